// File: doc/BRIEF.md
# Serial Clock Sequencer with Table Repeats

This block plays a nine-entry timing table onto a 3-bit serial clock output from a 100 MHz clock, so one cycle is one 10 ns unit. Each table entry pairs a 10-bit hold time with a 3-bit output pattern. A slice whose hold field is `d` holds its pattern for `d + 1` cycles. The table comes in as eight 16-bit words on one wide input. The block captures these words, together with an iteration count, on a start pulse. Inputs that change after that point do not affect the run in progress.

A run consists of a fixed start-up gap, then one or more iterations. Each iteration opens with a fixed gap and then plays the table. A 6-bit repeat field replays the table back to back inside each iteration, with no gap between passes. A parent sequencer can therefore launch this block once per parent iteration and wait for its one-cycle completion pulse.

Top module: `serial_clock_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `sclk` are all 0.
- R2: A `start` pulse sampled while idle raises `busy` on the next cycle. It captures `prog` and `iter_count`, and changes to either input during the run have no effect on that run.
- R3: A run begins with 2 cycles of start-up in which `busy` is 1 and `sclk` is 0.
- R4: Each iteration begins with 5 cycles of gap in which `sclk` is 0, followed directly by the first table slice.
- R5: Slice i (0..8) holds for d_i + 1 cycles. d_i is bits [10i+9:10i] of `prog`, where word k sits at `prog[16k+15:16k]`. Slice 3 therefore straddles words 1 and 2, and slice 8 is word 5 bits [9:0].
- R6: During slice i, `sclk` equals `prog[96+3i+2:96+3i]`: bit 0 of the field drives `sclk[0]` and bit 2 drives `sclk[2]`. Pattern 5 straddles word 6 bit 15 and word 7 bits [1:0]. Word 7 bits [15:11] are unused.
- R7: The repeat field R is word 5 bits [15:10]. Each iteration plays the table R+1 times, with slice 0 directly following slice 8 and no gap cycle.
- R8: `iter_count` K sets the number of iterations. When K = 0, the run is only the start-up gap.
- R9: A run keeps `busy` high for exactly 2 + K*(5 + (R+1)*sum(d_i+1)) cycles. `done` pulses for one cycle on the first cycle after `busy` falls.
- R10: A `start` pulse while `busy` is 1 is ignored: the run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock, one cycle per 10 ns unit |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| iter_count | input | 8 | Number of iterations, captured at launch |
| prog | input | 128 | Eight packed 16-bit table words, word 0 in the low bits |
| sclk | output | 3 | Serial clock pattern output |
| busy | output | 1 | High from the cycle after launch to the end of the run |
| done | output | 1 | One-cycle pulse after the run ends |

## Verification
The hardest situations to reach are a new launch and new table words arriving in the middle of a run. The bench pulses `start` once during the iteration gap and once during table playback. At the same time it inverts `prog` and zeroes `iter_count`, then checks that the cycle-by-cycle trace still matches the original table. Pattern fields that straddle word boundaries and full-range 1023 hold times are also reached. The bench does this by loading selected slices with extreme values and comparing every cycle against a model built from the requirements.

// File: rtl/serial_clock_sequencer.sv
module serial_clock_sequencer #(
  parameter int WORD_W      = 16,
  parameter int NWORDS      = 8,
  parameter int SLICES      = 9,
  parameter int DUR_W       = 10,
  parameter int REP_W       = 6,
  parameter int PAT_W       = 3,
  parameter int ITER_W      = 8,
  parameter int BOOT_CYC    = 2,
  parameter int ITER_OH_CYC = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ITER_W-1:0]        iter_count,
  input  logic [WORD_W*NWORDS-1:0] prog,
  output logic [PAT_W-1:0]         sclk,
  output logic                     busy,
  output logic                     done
);
  localparam int PROG_W  = WORD_W * NWORDS;
  localparam int REP_LSB = SLICES * DUR_W;
  localparam int PAT_LSB = REP_LSB + REP_W;
  localparam int USED_W  = PAT_LSB + SLICES * PAT_W;
  localparam int IDX_W   = $clog2(SLICES);
  localparam int CNT_W   = DUR_W;

  typedef enum logic [1:0] {S_IDLE, S_BOOT, S_GAP, S_PLAY} phase_t;

  phase_t             phase;
  logic [USED_W-1:0]  prog_q;
  logic [ITER_W-1:0]  iter_left;
  logic [REP_W-1:0]   rep_left;
  logic [IDX_W-1:0]   sidx;
  logic [CNT_W-1:0]   cnt;
  logic               done_q;
  logic               unused_bits;

  assign unused_bits = ^prog[PROG_W-1:USED_W];

  logic [CNT_W-1:0] dur_first, dur_next;
  logic [PAT_W-1:0] pat_now;
  assign dur_first = prog_q[DUR_W-1:0];
  assign dur_next  = prog_q[(int'(sidx) + 1) * DUR_W +: DUR_W];
  assign pat_now   = prog_q[PAT_LSB + int'(sidx) * PAT_W +: PAT_W];

  assign sclk = (phase == S_PLAY) ? pat_now : '0;
  assign busy = (phase != S_IDLE);
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      prog_q    <= '0;
      iter_left <= '0;
      rep_left  <= '0;
      sidx      <= '0;
      cnt       <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase == S_IDLE) begin
        if (start) begin
          prog_q    <= prog[USED_W-1:0];
          iter_left <= iter_count;
          cnt       <= CNT_W'(BOOT_CYC - 1);
          phase     <= S_BOOT;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (phase)
          S_BOOT: begin
            if (iter_left == '0) begin
              phase  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              phase <= S_GAP;
              cnt   <= CNT_W'(ITER_OH_CYC - 1);
            end
          end
          S_GAP: begin
            phase    <= S_PLAY;
            sidx     <= '0;
            rep_left <= prog_q[REP_LSB +: REP_W];
            cnt      <= dur_first;
          end
          default: begin
            if (sidx != IDX_W'(SLICES - 1)) begin
              sidx <= sidx + 1'b1;
              cnt  <= dur_next;
            end else if (rep_left != '0) begin
              rep_left <= rep_left - 1'b1;
              sidx     <= '0;
              cnt      <= dur_first;
            end else if (iter_left == ITER_W'(1)) begin
              phase  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              iter_left <= iter_left - 1'b1;
              phase     <= S_GAP;
              cnt       <= CNT_W'(ITER_OH_CYC - 1);
            end
          end
        endcase
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == '0 && !(done && $past(done))));

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_boot_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sclk == '0 && phase == S_BOOT));

  p_gap_to_first_slice_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_PLAY && $past(phase) == S_GAP) |-> (sidx == '0 && $past(cnt) == '0));

  p_rep_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_PLAY) |-> (rep_left <= prog_q[REP_LSB +: REP_W]));

  p_done_after_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase == S_PLAY) |=> (phase != S_BOOT));
endmodule

// File: tb/tb_serial_clock_sequencer.sv
module tb_serial_clock_sequencer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [7:0]   iter_count = '0;
  logic [127:0] prog = '0;
  logic [2:0]   sclk;
  logic         busy, done;

  serial_clock_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
    .prog(prog), .sclk(sclk), .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, wd = 0;
  int cd [9];
  int cp [9];
  int crep, cit, mism, nbusy, cyc;
  bit poke;

  // stimulus table: {iter, rep, dur base, dur step, pat base, pat step, expected busy cycles}
  localparam int NV = 4;
  localparam int TBL [NV][7] = '{
    '{1, 0, 1, 0, 0, 1,  25},
    '{2, 1, 0, 1, 7, 3, 192},
    '{1, 2, 3, 2, 5, 7, 331},
    '{3, 0, 2, 0, 2, 5,  98}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic logic [127:0] pack_prog();
    logic [127:0] p = '0;
    for (int i = 0; i < 9; i++) begin
      p[10*i +: 10] = 10'(cd[i]);
      p[96 + 3*i +: 3] = 3'(cp[i]);
    end
    p[95:90] = 6'(crep);
    p[127:123] = 5'b10101;
    return p;
  endfunction

  task automatic step(input logic eb, input logic [2:0] es);
    @(negedge clk);
    cyc++;
    if (busy === 1'b1) nbusy++;
    if (busy !== eb || sclk !== es) begin
      if (mism == 0)
        $display("FAIL R5/R6 trace cycle %0d actual busy=%b sclk=%0d expected busy=%b sclk=%0d",
                 cyc, busy, sclk, eb, es);
      mism++;
    end
    if (poke && (cyc == 3 || cyc == 12)) begin
      start = 1'b1;
      prog = ~prog;
      iter_count = 8'd0;
    end else begin
      start = 1'b0;
    end
  endtask

  task automatic run(input int exp_total, input string tag);
    int total;
    total = 0;
    prog = pack_prog();
    iter_count = 8'(cit);
    mism = 0; nbusy = 0; cyc = 0;
    start = 1'b1;
    for (int b = 0; b < 2; b++) step(1'b1, 3'd0);
    for (int k = 0; k < cit; k++) begin
      for (int g = 0; g < 5; g++) step(1'b1, 3'd0);
      for (int r = 0; r <= crep; r++)
        for (int i = 0; i < 9; i++)
          for (int c = 0; c <= cd[i]; c++) step(1'b1, 3'(cp[i]));
    end
    checks++;
    if (mism != 0) fails++;
    total = 2;
    for (int k = 0; k < cit; k++) begin
      total += 5;
      for (int r = 0; r <= crep; r++)
        for (int i = 0; i < 9; i++) total += cd[i] + 1;
    end
    check(nbusy == exp_total && total == exp_total, {"R9 busy length ", tag}, nbusy, exp_total);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, {"R9 done pulse ", tag}, int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, {"R9 done single cycle ", tag}, int'(done), 0);
    poke = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    poke = 1'b0;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    check(done === 1'b0, "R1 reset done", int'(done), 0);
    check(sclk === 3'd0, "R1 reset sclk", int'(sclk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 idle after reset", int'(busy), 0);

    // R3 R4 R5 R6 R7 R8 R9: table walk
    for (int v = 0; v < NV; v++) begin
      cit = TBL[v][0]; crep = TBL[v][1];
      for (int i = 0; i < 9; i++) begin
        cd[i] = TBL[v][2] + TBL[v][3] * i;
        cp[i] = (TBL[v][4] + TBL[v][5] * i) % 8;
      end
      run(TBL[v][6], $sformatf("vector %0d", v));
    end

    // R8: zero iterations
    cit = 0; crep = 5;
    for (int i = 0; i < 9; i++) begin cd[i] = 3; cp[i] = 7; end
    run(2, "R8 zero iterations");

    // R7: maximum repeat count, zero hold times
    cit = 1; crep = 63;
    for (int i = 0; i < 9; i++) begin cd[i] = 0; cp[i] = i % 8; end
    run(583, "R7 repeat 63");

    // R5: full-range hold on straddling slice 3 and on slice 8
    cit = 1; crep = 0;
    for (int i = 0; i < 9; i++) begin cd[i] = 0; cp[i] = 7 - (i % 8); end
    cd[3] = 1023; cd[8] = 700; cp[5] = 5;
    run(1739, "R5 long slices");

    // R10 R2: start pulses and input changes mid-run are ignored
    cit = 1; crep = 0;
    for (int i = 0; i < 9; i++) begin cd[i] = 1; cp[i] = (3 + i) % 8; end
    poke = 1'b1;
    run(25, "R10 R2 start while busy");

    summary();
    $finish;
  end
endmodule